// File: doc/BRIEF.md
# Packed Halfword Arithmetic Right Shifter with Optional Rounding

This unit is a datapath slice for a DSP-style pipeline. A 32-bit operand carries two signed 16-bit lanes. Both lanes are shifted right arithmetically by the same 4-bit amount, and the two results are packed back into their original positions. A select bit chooses between plain truncation and round-to-nearest. Rounding adds one at the highest bit that the shift discards. The sum is formed in a 17-bit intermediate, so it can never wrap. No flags or exceptions are produced.

The unit accepts one operation per cycle, qualified by `in_valid`. The packed result appears one clock later, qualified by `out_valid`. Between operations the result register holds its value.

Next to the datapath sits a purely combinational instruction decoder. It pulls the destination register, source register, shift amount and rounding select out of a 32-bit instruction word. It raises `insn_match` only when all three fixed opcode fields carry their required values. When `insn_match` is low, the decoded fields carry no meaning.

Top module: `pair_shift_unit`

## Requirements
- R1: The high lane (bits 31..16) and the low lane (bits 15..0) are computed independently, and each result lands in the same bit positions as its source lane.
- R2: With `round_en`=0, each lane result is the lane shifted right by `shamt` (0 to 15), with the lane's bit 15 copied into every vacated upper bit. That is floor(a / 2^shamt) for signed a.
- R3: With `shamt`=0, each lane passes through unchanged, whether `round_en` is 0 or 1.
- R4: With `round_en`=1 and `shamt`>0, each lane result is floor((a + 2^(shamt-1)) / 2^shamt). The result always fits in 16 bits, so 0x7FFF shifted by 1 gives 0x4000 and never wraps negative.
- R5: Operations with different `round_en` values may follow one another on consecutive cycles, and each result uses the select bit that was presented with its own operand.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` updates only after an `in_valid` cycle and otherwise holds its value.
- R7: A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R8: Decoded fields are read from fixed bit positions of `insn_word`:
  - `dec_rt` = bits 25..21
  - `dec_rs` = bits 20..16
  - `dec_shamt` = bits 15..12
  - `dec_round` = bit 10
  - bit 11 is ignored.
- R9: `insn_match` is 1 only when all three of these hold:
  - bits 31..26 equal 001000
  - bits 9..3 equal 1100110
  - bits 2..0 equal 101

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src_word | input | 32 | Two packed signed halfwords |
| shamt | input | 4 | Shift amount, 0 to 15 |
| round_en | input | 1 | 1 selects the rounding shift |
| insn_word | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 32 | Packed shifted halfwords |
| insn_match | output | 1 | Opcode fields match the shift instruction |
| dec_rt | output | 5 | Decoded destination register field |
| dec_rs | output | 5 | Decoded source register field |
| dec_shamt | output | 4 | Decoded shift amount |
| dec_round | output | 1 | Decoded rounding select |

## Verification
The clocked properties assume that `src_word`, `shamt` and `round_en` are steady across the capturing edge whenever `in_valid` is high. They also assume that `rst` is released synchronously. The bench meets both assumptions by changing every input only on the falling clock edge. It raises `in_valid` for single cycles and holds the inputs low throughout reset. Operand values include both lane extremes (0x7FFF and 0x8000), lanes of opposite sign, and every shift amount in both variants. No input is left undriven.

// File: rtl/pair_shift_pkg.sv
package pair_shift_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int SA_W   = 4;

    localparam logic [5:0] MAJOR_CODE = 6'b001000;
    localparam logic [6:0] MINOR_CODE = 7'b1100110;
    localparam logic [2:0] FUNC_CODE  = 3'b101;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rs;
        logic [SA_W-1:0]  sa;
        logic             rnd;
    } insn_fields_t;
endpackage

// File: rtl/hsr_lane.sv
module hsr_lane #(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] sh,
    input  logic          rnd,
    output logic [W-1:0]  y
);
    logic signed [W:0]   ext;
    logic        [W:0]   sum;
    logic signed [W-1:0] plain;

    always_comb begin
        // One guard bit below the lane keeps the rounding position in range for every shift.
        ext   = $signed({a, 1'b0}) >>> sh;
        sum   = $unsigned(ext) + {{W{1'b0}}, 1'b1};
        plain = $signed(a) >>> sh;
        y     = rnd ? sum[W:1] : plain;
    end
endmodule

// File: rtl/hsr_decode.sv
module hsr_decode
    import pair_shift_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fields
);
    always_comb begin
        fields.hit = (insn[31:26] == MAJOR_CODE) &&
                     (insn[9:3]   == MINOR_CODE) &&
                     (insn[2:0]   == FUNC_CODE);
        fields.rt  = insn[25:21];
        fields.rs  = insn[20:16];
        fields.sa  = insn[15:12];
        fields.rnd = insn[10];
    end
endmodule

// File: rtl/pair_shift_unit.sv
module pair_shift_unit
    import pair_shift_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 2,
    parameter int SH_W   = $clog2(LANE_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANE_W*LANES-1:0]   src_word,
    input  logic [SH_W-1:0]           shamt,
    input  logic                      round_en,
    input  logic [INSN_W-1:0]         insn_word,
    output logic                      out_valid,
    output logic [LANE_W*LANES-1:0]   result,
    output logic                      insn_match,
    output logic [REG_W-1:0]          dec_rt,
    output logic [REG_W-1:0]          dec_rs,
    output logic [SA_W-1:0]           dec_shamt,
    output logic                      dec_round
);
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t            st_d, st_q;
    logic [DATA_W-1:0] lanes_y;
    insn_fields_t      fld;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hsr_lane #(.W(LANE_W), .SW(SH_W)) u_lane (
            .a   (src_word[g*LANE_W +: LANE_W]),
            .sh  (shamt),
            .rnd (round_en),
            .y   (lanes_y[g*LANE_W +: LANE_W])
        );
    end

    hsr_decode u_dec (
        .insn   (insn_word),
        .fields (fld)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = lanes_y;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign result     = st_q.res;
    assign insn_match = fld.hit;
    assign dec_rt     = fld.rt;
    assign dec_rs     = fld.rs;
    assign dec_shamt  = fld.sa;
    assign dec_round  = fld.rnd;
endmodule

// File: rtl/pair_shift_chk.sv
module pair_shift_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] src_word,
    input logic [3:0]  shamt,
    input logic        round_en,
    input logic [31:0] insn_word,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        insn_match
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6
    AST_VALID_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R6
    AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt == 4'd0) |=> result == $past(src_word)); // R3
    AST_FULL_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !round_en && shamt == 4'd15) |=>
        (result[31:16] == {16{$past(src_word[31])}} &&
         result[15:0]  == {16{$past(src_word[15])}})); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && round_en && !src_word[15] && !src_word[31]) |=>
        (!result[15] && !result[31])); // R4
    AST_MATCH_FIELDS: assert property (@(posedge clk) disable iff (rst)
        insn_match |-> (insn_word[31:26] == 6'b001000 &&
                        insn_word[9:3] == 7'b1100110 &&
                        insn_word[2:0] == 3'b101)); // R9
endmodule

bind pair_shift_unit pair_shift_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .src_word   (src_word),
    .shamt      (shamt),
    .round_en   (round_en),
    .insn_word  (insn_word),
    .out_valid  (out_valid),
    .result     (result),
    .insn_match (insn_match)
);

// File: tb/pair_shift_unit_test.sv
`timescale 1ns/1ps
module pair_shift_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] src_word = '0;
    logic [3:0]  shamt = '0;
    logic        round_en = 1'b0;
    logic [31:0] insn_word = '0;
    logic        out_valid, insn_match, dec_round;
    logic [31:0] result;
    logic [4:0]  dec_rt, dec_rs;
    logic [3:0]  dec_shamt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pair_shift_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
        .shamt(shamt), .round_en(round_en), .insn_word(insn_word),
        .out_valid(out_valid), .result(result), .insn_match(insn_match),
        .dec_rt(dec_rt), .dec_rs(dec_rs), .dec_shamt(dec_shamt), .dec_round(dec_round)
    );

    function automatic logic [15:0] ref_lane(logic [15:0] a, int s, bit r);
        int v;
        v = $signed(a);
        if (r && s > 0) v = (v + (1 << (s - 1))) >>> s;
        else            v = v >>> s;
        return v[15:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w, int s, bit r, string req);
        logic [31:0] exp;
        @(negedge clk);
        src_word = w; shamt = 4'(s); round_en = r; in_valid = 1'b1;
        exp = {ref_lane(w[31:16], s, r), ref_lane(w[15:0], s, r)};
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, result, exp);
    endtask

    task automatic t_reset;
        check("R7 valid", {31'd0, out_valid}, 32'd0);
        check("R7 result", result, 32'd0);
    endtask

    task automatic t_extremes;
        apply(32'h7FFF_8000, 1, 1'b1, "R4");
        check("R4 no wrap", result, 32'h4000_C000);
        apply(32'h8000_7FFF, 15, 1'b0, "R2");
        check("R2 sign fill", result, 32'hFFFF_0000);
        apply(32'h7FFF_7FFF, 15, 1'b1, "R4");
        apply(32'h8000_8000, 0, 1'b1, "R3");
        apply(32'h8000_7FFF, 0, 1'b0, "R3");
    endtask

    task automatic t_sweep;
        logic [31:0] pats [4] = '{32'h7FFF_8000, 32'h1234_EDCB, 32'h0001_FFFF, 32'hA5A5_5A5A};
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 16; s++) begin
                apply(pats[p], s, 1'b0, "R2");
                apply(pats[p], s, 1'b1, "R4");
            end
    endtask

    task automatic t_opposite;
        apply(32'h0003_FFFD, 1, 1'b1, "R1");
        check("R1 lanes", result, 32'h0002_FFFF);
        apply(32'hFFF8_0007, 2, 1'b0, "R1");
        check("R1 lanes", result, 32'hFFFE_0001);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        src_word = 32'h0005_FFFB; shamt = 4'd1; round_en = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R5 first", result, 32'h0002_FFFD);
        round_en = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 second", result, 32'h0003_FFFE);
        @(negedge clk);
        check("R6 hold", result, 32'h0003_FFFE);
        check("R6 valid low", {31'd0, out_valid}, 32'd0);
        src_word = 32'h1111_1111;
        @(negedge clk);
        check("R6 ignored", result, 32'h0003_FFFE);
    endtask

    task automatic t_decode;
        logic [31:0] w;
        w = {6'b001000, 5'd17, 5'd9, 4'd11, 1'b1, 1'b1, 7'b1100110, 3'b101};
        insn_word = w; #1;
        check("R9 match", {31'd0, insn_match}, 32'd1);
        check("R8 fields", {15'd0, dec_rt, dec_rs, dec_shamt, 2'b00, dec_round}, {15'd0, 5'd17, 5'd9, 4'd11, 3'b001});
        insn_word = w & ~32'h0000_0C00; #1;
        check("R8 round0", {31'd0, dec_round}, 32'd0);
        check("R9 match x", {31'd0, insn_match}, 32'd1);
        insn_word = w ^ 32'h0400_0000; #1;
        check("R9 major", {31'd0, insn_match}, 32'd0);
        insn_word = w ^ 32'h0000_0008; #1;
        check("R9 minor", {31'd0, insn_match}, 32'd0);
        insn_word = w ^ 32'h0000_0001; #1;
        check("R9 func", {31'd0, insn_match}, 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_extremes;
        t_sweep;
        t_opposite;
        t_back_to_back;
        t_decode;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        t_reset;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule